// File: doc/BRIEF.md
# Secure/Non-secure Engine Ownership Lock

This block decides which security world may use a shared public-key engine at a given time. Every APB access carries a world attribute (`pnonsec`). A CPU claims the engine by reading the lock register. A read that returns zero means the reader now owns the engine, and the block records which world claimed it. The owner gives the engine back by writing zero to the same register.

While the engine is owned, register accesses to the engine window from the other world are refused. A Secure-only overwrite register lets Secure software take the engine away from a Non-secure owner; the reverse is not possible. Each time ownership ends, by a voluntary release or by a forced takeover, the block sends a one-cycle clear pulse to the engine so that no keys or intermediate values survive for the next user.

The register map sits on an `ADDR_W`-bit byte address. The lock register is at offset 0x00. The overwrite register is at 0x04. Every address at or above `ENG_BASE` (default 0x40) belongs to the engine window. `pready` is always high, so every access completes in its first access-phase cycle.

Top module: `eng_own_lock`

## Requirements
- R1: A read of the lock register (offset 0x00) while it is free returns 0 with no error. The lock then holds owner code 2'b01 if the read was Secure (`pnonsec`=0) or 2'b10 if it was Non-secure (`pnonsec`=1). The code appears on `owner` after that clock edge.
- R2: A read of the lock register while it is owned returns the current owner code, zero-extended, with no error, and leaves the owner unchanged.
- R3: A write of an all-zero word to the lock register from the owning world releases the lock: `owner` reads 2'b00 after that edge.
- R4: A write to an owned lock register from the non-owning world is ignored and completes with `pslverr`=1. A write of a nonzero word, or any write to a free lock, is ignored with no error.
- R5: An access to the engine window (`paddr` >= `ENG_BASE`) is forwarded (`eng_req`=1, `eng_wr`=`pwrite`, read data from `eng_rdata`) only when the world of the access owns the lock. Otherwise, including while the lock is free, it completes with `pslverr`=1, read data 0 and `eng_req`=0.
- R6: Any Non-secure access to the overwrite register (offset 0x04) is ignored, reads as 0 and completes with `pslverr`=1.
- R7: A Secure write to the overwrite register while the lock holds 2'b10 frees the lock. The same write under any other owner code has no effect. Secure reads of it return 0 with no error.
- R8: `eng_clr` is high for exactly the one cycle after the edge that accepts a release, whether voluntary (R3) or forced (R7). It stays low at all other times, including for ignored writes.
- R9: While the lock holds 2'b01, no Non-secure access changes the owner.
- R10: Reads of unmapped addresses return 0 with no error and change nothing. `pready` is always 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | DATA_W | APB write data |
| pnonsec | input | 1 | World of the access, 1 = Non-secure |
| prdata | output | DATA_W | APB read data |
| pready | output | 1 | Always 1 |
| pslverr | output | 1 | Access refused or ignored with error |
| eng_req | output | 1 | Permitted access to the engine register file |
| eng_wr | output | 1 | The permitted engine access is a write |
| eng_rdata | input | DATA_W | Engine register read data |
| eng_clr | output | 1 | One-cycle wipe of all engine state |
| owner | output | 2 | Current owner code (00 free, 01 Secure, 10 Non-secure) |

## Verification
The bench attacks the asymmetry between the worlds. It checks that a Non-secure release or overwrite aimed at a Secure lock leaves the owner in place; a design that decoded the world loosely would let Non-secure software steal the engine. It checks that a second read of a held lock reports the owner and does not re-record it; a design that re-acquired on every read would hand ownership to the second reader. The bench also tracks every cycle of `eng_clr`. A missing pulse after a forced takeover would leak key material. A pulse after an ignored or cross-world write would wipe the engine while its owner is still using it.

// File: rtl/mtx_pkg.sv
package mtx_pkg;
  typedef enum logic [1:0] {
    OWN_FREE = 2'b00,
    OWN_SEC  = 2'b01,
    OWN_NSEC = 2'b10
  } own_e;

  typedef enum logic [1:0] {
    RGN_NONE,
    RGN_LOCK,
    RGN_OVR,
    RGN_ENG
  } rgn_e;

  // owner code a given world records when it acquires
  function automatic own_e world_code(input logic ns);
    return ns ? OWN_NSEC : OWN_SEC;
  endfunction

  // true when the world of the access currently holds the lock
  function automatic logic world_owns(input own_e o, input logic ns);
    return (o != OWN_FREE) && (o == world_code(ns));
  endfunction
endpackage

// File: rtl/mtx_decode.sv
module mtx_decode
  import mtx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int LOCK_OFS = 0,
  parameter int OVR_OFS  = 4,
  parameter int ENG_BASE = 64
) (
  input  logic [ADDR_W-1:0] addr,
  output rgn_e              region
);
  localparam logic [ADDR_W-1:0] LockA = ADDR_W'(LOCK_OFS);
  localparam logic [ADDR_W-1:0] OvrA  = ADDR_W'(OVR_OFS);
  localparam logic [ADDR_W-1:0] EngA  = ADDR_W'(ENG_BASE);

  always_comb begin
    if (addr >= EngA)       region = RGN_ENG;
    else if (addr == LockA) region = RGN_LOCK;
    else if (addr == OvrA)  region = RGN_OVR;
    else                    region = RGN_NONE;
  end
endmodule

// File: rtl/mtx_lock_fsm.sv
module mtx_lock_fsm
  import mtx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic acc,
  input  logic wr,
  input  logic ns,
  input  logic wzero,
  input  rgn_e region,
  output own_e owner,
  output logic acquire,
  output logic rel_ok,
  output logic force_ok,
  output logic lock_err,
  output logic clr
);
  own_e owner_q;
  logic clr_q;
  logic rd_lock, wr_lock;

  assign rd_lock  = acc && !wr && (region == RGN_LOCK);
  assign wr_lock  = acc &&  wr && (region == RGN_LOCK);
  assign acquire  = rd_lock && (owner_q == OWN_FREE);
  assign lock_err = wr_lock && (owner_q != OWN_FREE) && !world_owns(owner_q, ns);
  assign rel_ok   = wr_lock && wzero && world_owns(owner_q, ns);
  assign force_ok = acc && wr && (region == RGN_OVR) && !ns && (owner_q == OWN_NSEC);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q <= OWN_FREE;
      clr_q   <= 1'b0;
    end else begin
      if (acquire)               owner_q <= world_code(ns);
      else if (rel_ok || force_ok) owner_q <= OWN_FREE;
      clr_q <= rel_ok || force_ok;
    end
  end

  assign owner = owner_q;
  assign clr   = clr_q;

  // R1
  acq_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_FREE && rd_lock) |=> (owner_q == world_code($past(ns))));
  // R9
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q == OWN_SEC && !rel_ok) |=> (owner_q == OWN_SEC));
  // R2
  held_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (owner_q != OWN_FREE && !rel_ok && !force_ok) |=> (owner_q == $past(owner_q)));
  // R8
  clr_after_rel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rel_ok || force_ok) |=> (clr_q && owner_q == OWN_FREE));
  // R8
  clr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_q |=> !clr_q);
endmodule

// File: rtl/eng_own_lock.sv
module eng_own_lock
  import mtx_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int LOCK_OFS = 0,
  parameter int OVR_OFS  = 4,
  parameter int ENG_BASE = 64
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  input  logic              pnonsec,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  output logic              pslverr,
  output logic              eng_req,
  output logic              eng_wr,
  input  logic [DATA_W-1:0] eng_rdata,
  output logic              eng_clr,
  output logic [1:0]        owner
);
  rgn_e region;
  own_e own;
  logic acc, acquire, rel_ok, force_ok, lock_err, allow;

  assign acc = psel && penable;

  mtx_decode #(
    .ADDR_W(ADDR_W), .LOCK_OFS(LOCK_OFS), .OVR_OFS(OVR_OFS), .ENG_BASE(ENG_BASE)
  ) u_dec (
    .addr(paddr), .region(region)
  );

  mtx_lock_fsm u_fsm (
    .clk(pclk), .rst_n(presetn), .acc(acc), .wr(pwrite), .ns(pnonsec),
    .wzero(pwdata == '0), .region(region), .owner(own), .acquire(acquire),
    .rel_ok(rel_ok), .force_ok(force_ok), .lock_err(lock_err), .clr(eng_clr)
  );

  assign allow   = world_owns(own, pnonsec);
  assign eng_req = acc && (region == RGN_ENG) && allow;
  assign eng_wr  = eng_req && pwrite;
  assign pready  = 1'b1;
  assign owner   = own;

  always_comb begin
    prdata  = '0;
    pslverr = 1'b0;
    case (region)
      RGN_LOCK: begin
        if (!pwrite) prdata = DATA_W'(own);
        pslverr = lock_err;
      end
      RGN_OVR:  pslverr = acc && pnonsec;
      RGN_ENG: begin
        if (allow && !pwrite) prdata = eng_rdata;
        pslverr = acc && !allow;
      end
      default: ;
    endcase
  end

  // R5
  eng_owned_chk: assert property (@(posedge pclk) disable iff (!presetn)
    eng_req |-> (own != OWN_FREE && !pslverr));
  // R6
  ovr_ns_chk: assert property (@(posedge pclk) disable iff (!presetn)
    (acc && region == RGN_OVR && pnonsec) |-> (pslverr && prdata == '0 && !force_ok));
  // R1
  acq_zero_chk: assert property (@(posedge pclk) disable iff (!presetn)
    acquire |-> (prdata == '0 && !pslverr));
endmodule

// File: tb/eng_own_lock_bench.sv
module eng_own_lock_bench;
  logic        pclk = 1'b0;
  logic        presetn = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pnonsec = 1'b0;
  logic [7:0]  paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata, eng_rdata;
  logic        pready, pslverr, eng_req, eng_wr, eng_clr;
  logic [1:0]  owner;

  int errors = 0, checks = 0;
  int m_lock = 0;
  bit m_clr = 0;
  bit live = 0;
  bit done = 0;

  always #2.5 pclk = ~pclk;
  assign eng_rdata = {24'hC0FFEE, paddr};

  eng_own_lock u_eng_own_lock (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pnonsec(pnonsec), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .eng_req(eng_req), .eng_wr(eng_wr), .eng_rdata(eng_rdata),
    .eng_clr(eng_clr), .owner(owner)
  );

  task automatic chk(input bit ok, input string r, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", r, got, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // per-cycle comparison of state outputs against the model
  always @(posedge pclk) begin
    #1;
    if (live) begin
      chk(owner == 2'(m_lock), "R9 owner", 32'(owner), 32'(m_lock));
      chk(eng_clr == m_clr, "R8 clear", 32'(eng_clr), 32'(m_clr));
      m_clr = 0;
    end
  end

  // one APB transfer; expectations come from the behavioural model
  task automatic xfer(input bit wr, input logic [7:0] a, input logic [31:0] d, input bit ns);
    int own_w = ns ? 2 : 1;
    logic [31:0] e_rd = 0;
    bit e_err = 0, e_req = 0, rel = 0;
    int nxt = m_lock;
    string r;
    if (a == 8'h00) begin
      if (!wr) begin
        e_rd = 32'(m_lock);
        r = (m_lock == 0) ? "R1" : "R2";
        if (m_lock == 0) nxt = own_w;
      end else if (m_lock != 0 && m_lock != own_w) begin
        e_err = 1; r = "R4";
      end else if (m_lock == own_w && d == 0) begin
        rel = 1; r = "R3";
      end else r = "R4";
    end else if (a == 8'h04) begin
      if (ns) begin e_err = 1; r = "R6"; end
      else begin
        r = "R7";
        if (wr && m_lock == 2) rel = 1;
      end
    end else if (a >= 8'h40) begin
      r = "R5";
      e_req = (m_lock == own_w);
      e_err = !e_req;
      if (e_req) e_rd = {24'hC0FFEE, a};
    end else r = "R10";
    @(negedge pclk);
    psel = 1; penable = 0; pwrite = wr; paddr = a; pwdata = d; pnonsec = ns;
    @(negedge pclk);
    penable = 1;
    #1;
    chk(pslverr == e_err, {r, " pslverr"}, 32'(pslverr), 32'(e_err));
    chk(eng_req == e_req, {r, " eng_req"}, 32'(eng_req), 32'(e_req));
    chk(eng_wr == (e_req && wr), {r, " eng_wr"}, 32'(eng_wr), 32'(e_req && wr));
    chk(pready == 1'b1, "R10 pready", 32'(pready), 32'd1);
    if (!wr) chk(prdata == e_rd, {r, " prdata"}, prdata, e_rd);
    @(posedge pclk);
    if (rel) begin m_lock = 0; m_clr = 1; end
    else m_lock = nxt;
    @(negedge pclk);
    psel = 0; penable = 0;
  endtask

  initial begin
    #(200000 * 5);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge pclk);
    // reset state
    chk(owner == 2'b00, "R1 reset owner", 32'(owner), 0);
    chk(eng_clr == 0, "R8 reset clear", 32'(eng_clr), 0);
    presetn = 1;
    live = 1;
    // R1: Secure acquires; R2: re-reads by both worlds
    xfer(0, 8'h00, 0, 0);
    xfer(0, 8'h00, 0, 0);
    xfer(0, 8'h00, 0, 1);
    // R5/R9: Non-secure blocked from a Secure-owned engine
    xfer(0, 8'h44, 0, 1);
    xfer(1, 8'h48, 32'h1234, 1);
    xfer(1, 8'h00, 0, 1);            // R4 cross-world release
    xfer(1, 8'h04, 32'h1, 1);        // R6
    xfer(0, 8'h04, 0, 1);            // R6
    xfer(0, 8'h44, 0, 0);            // R5 permitted
    xfer(1, 8'hFC, 32'hDEAD, 0);     // R5 permitted write
    xfer(1, 8'h04, 32'h1, 0);        // R7 no effect on Secure lock
    xfer(0, 8'h04, 0, 0);            // R7 read zero
    xfer(1, 8'h00, 32'h5, 0);        // R4 nonzero write ignored
    xfer(0, 8'h10, 0, 0);            // R10 unmapped
    xfer(1, 8'h00, 0, 0);            // R3 release, R8 pulse
    // Non-secure owner, then forced takeover
    xfer(0, 8'h00, 0, 1);            // R1
    xfer(0, 8'h40, 0, 1);            // R5
    xfer(0, 8'h40, 0, 0);            // R5 Secure blocked
    xfer(1, 8'h00, 0, 0);            // R4
    xfer(1, 8'h04, 32'h1, 0);        // R7 forced free, R8 pulse
    // free lock corner cases
    xfer(0, 8'h40, 0, 0);            // R5 blocked when free
    xfer(1, 8'h00, 0, 1);            // R4 write to free lock: no pulse
    xfer(1, 8'h04, 32'h1, 0);        // R7 no effect when free
    // Non-secure voluntary release
    xfer(0, 8'h00, 0, 1);
    xfer(1, 8'h00, 0, 1);            // R3
    xfer(0, 8'h00, 0, 0);
    xfer(1, 8'h00, 0, 0);
    repeat (4) @(negedge pclk);
    finish_run();
  end
endmodule